// File: doc/BRIEF.md
# NAND Boot Image Loader with Bad-Block Skipping

This block walks a NAND device one erase block at a time and copies a boot image of a given byte length into destination memory. It needs only a starting byte offset, the image length and a destination base address. For every page it asks a separate page-read engine for an ECC-checked read, and with the request it supplies the page number and the destination address for that page's data. The engine reports the result of each of the four subpage decodes and returns the first two spare bytes of the first subpage. The loader uses these to decide whether the page could be read and whether the block carries a bad-block marker.

A block is dropped when a readable page carries a marker, or when none of the pages read in it could be decoded. A dropped block costs no image length and does not move the destination pointer, and the walk goes on 64 pages further. Decode failures matter only in blocks that turn out to be good: in such a block they end the load with an error. The loader also keeps the largest corrected-error count seen on any readable page. The NAND protocol, the decoder and the memory write path all sit behind the page-read engine.

Top module: `nand_boot_loader`

## Requirements
- R1: The first page requested is the start offset divided by the page size (2048 bytes by default; remainder dropped), with destination address equal to the destination base. Within a block, consecutive requests advance the page by one and the destination by one page size.
- R2: A page is readable when none of its subpage fail bits is set. A readable page whose spare byte 0 or spare byte 1 differs from 0xFF marks its block bad. No further page of that block is requested.
- R3: A block in which no requested page was readable is skipped in the same way as a marked block.
- R4: A block with at least one unreadable page, at least one readable page and no marker ends the load with `error` high and `done` low. No further request follows. `done` and `error` are never high together.
- R5: A skipped block leaves the remaining length and the destination pointer unchanged, and the next block starts one block (64 pages by default) after the skipped block's first page. A kept block reduces the remaining length by min(remaining, block bytes). The load ends with `done` when the remaining length reaches zero.
- R6: The number of pages requested in a block that is not cut short is the remaining length rounded up to whole pages, capped at the block's page count.
- R7: `max_flips` is the largest per-page corrected-error count over all readable pages of the current load. A subpage contributes its 2-bit count field plus one (1..4) when its error flag is set, and 0 otherwise. It is cleared by an accepted start.
- R8: `start` is ignored while `busy` is high. An image length of zero gives `done` at once with no request. `done` and `error` hold until the next accepted start, which clears both.
- R9: `rd_req` stays high with stable `rd_page` and `rd_dest` until `rd_gnt`. It stays low from the grant until `rd_rsp`, so only one read is ever outstanding.
- R10: After reset the loader is idle: `busy`, `rd_req`, `done` and `error` are low and `max_flips` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_offset | input | ADDR_W | Byte offset of the image in NAND |
| image_size | input | SIZE_W | Image length in bytes |
| dest_base | input | ADDR_W | Destination base address |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished successfully (held) |
| error | output | 1 | Load aborted by a read error in a good block (held) |
| max_flips | output | FLIP_W | Largest corrected-error count of the load |
| rd_req | output | 1 | Page read request |
| rd_page | output | PAGE_W | Page number to read |
| rd_dest | output | ADDR_W | Destination address for the page's data |
| rd_gnt | input | 1 | Page-read engine accepts the request |
| rd_rsp | input | 1 | Page read complete, status valid |
| rd_sub_fail | input | SUBPAGES | Per-subpage uncorrectable flag |
| rd_sub_flag | input | SUBPAGES | Per-subpage corrected-error flag |
| rd_sub_cnt | input | SUBPAGES*CNT_W | Per-subpage corrected count minus one |
| rd_spare0 | input | 8 | Spare byte 0 of the first subpage |
| rd_spare1 | input | 8 | Spare byte 1 of the first subpage |

## Verification
The bench builds the loader with 8-page erase blocks (PPB_LG2 = 3) and a 12-bit page number, and keeps the 2048-byte page and four 2-bit subpage counts. Small blocks let one short run cross several blocks. In that space a run reaches a partial last block, skips in a row, marked blocks whose scan stops early, and blocks whose decode failures are forgiven because the block is bad, with unaligned start offsets. Image lengths are drawn up to four blocks, and per-block fault modes are drawn for the first eight blocks after the start page.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BLOCK,
      ST_REQ,
      ST_WAIT,
      ST_DECIDE
   } ld_state_e;
endpackage

// File: rtl/nbl_page_judge.sv
module nbl_page_judge #(
   parameter int SUBPAGES = 4,
   parameter int CNT_W    = 2,
   parameter int FLIP_W   = CNT_W + 1
) (
   input  logic [SUBPAGES-1:0]       sub_fail,
   input  logic [SUBPAGES-1:0]       sub_flag,
   input  logic [SUBPAGES*CNT_W-1:0] sub_cnt,
   input  logic [7:0]                spare0,
   input  logic [7:0]                spare1,
   output logic                      page_fail,
   output logic                      page_marked,
   output logic [FLIP_W-1:0]         page_flips
);
   if (SUBPAGES < 1) begin : g_chk_sub
      $error("nbl_page_judge: SUBPAGES must be at least 1");
   end
   if (FLIP_W < CNT_W + 1) begin : g_chk_flip
      $error("nbl_page_judge: FLIP_W too narrow for count plus one");
   end

   assign page_fail   = |sub_fail;
   assign page_marked = (spare0 != 8'hFF) || (spare1 != 8'hFF);

   // worst subpage: a flagged subpage reports its field plus one
   always_comb begin
      logic [FLIP_W-1:0] cand;
      page_flips = '0;
      for (int s = 0; s < SUBPAGES; s++) begin
         cand = sub_flag[s] ? (FLIP_W'(sub_cnt[s*CNT_W +: CNT_W]) + FLIP_W'(1)) : '0;
         if (cand > page_flips) page_flips = cand;
      end
   end
endmodule

// File: rtl/nbl_block_span.sv
module nbl_block_span #(
   parameter int PAGE_LG2 = 11,
   parameter int PPB_LG2  = 6,
   parameter int SIZE_W   = 32
) (
   input  logic [SIZE_W-1:0]  bytes_left,
   output logic [PPB_LG2:0]   blk_pages,
   output logic [SIZE_W-1:0]  blk_bytes
);
   localparam int BLK_LG2 = PAGE_LG2 + PPB_LG2;
   localparam logic [SIZE_W-1:0] BLK_BYTES = SIZE_W'(1) << BLK_LG2;
   localparam logic [SIZE_W-1:0] PPB_WIDE  = SIZE_W'(1) << PPB_LG2;
   localparam logic [PPB_LG2:0]  PPB_CNT   = (PPB_LG2+1)'(1) << PPB_LG2;

   if (PAGE_LG2 < 1 || PPB_LG2 < 1) begin : g_chk_geom
      $error("nbl_block_span: page and block exponents must be positive");
   end
   if (SIZE_W <= BLK_LG2) begin : g_chk_size
      $error("nbl_block_span: SIZE_W cannot hold one block of bytes");
   end

   logic [SIZE_W-1:0] whole_pages;
   logic              tail;
   logic [SIZE_W-1:0] need;

   assign whole_pages = bytes_left >> PAGE_LG2;
   assign tail        = |bytes_left[PAGE_LG2-1:0];
   assign need        = whole_pages + SIZE_W'(tail);
   assign blk_pages   = (need >= PPB_WIDE) ? PPB_CNT : need[PPB_LG2:0];
   assign blk_bytes   = (bytes_left >= BLK_BYTES) ? BLK_BYTES : bytes_left;
endmodule

// File: rtl/nbl_block_tally.sv
module nbl_block_tally #(
   parameter int PPB_LG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PPB_LG2:0] load_pages,
   input  logic             step,
   input  logic             step_ok,
   input  logic             step_marked,
   output logic             last,
   output logic             any_good,
   output logic             any_err,
   output logic             marked
);
   localparam logic [PPB_LG2:0] PPB_CNT = (PPB_LG2+1)'(1) << PPB_LG2;

   logic [PPB_LG2:0] remaining_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining_q <= '0;
         any_good    <= 1'b0;
         any_err     <= 1'b0;
         marked      <= 1'b0;
      end else if (load) begin
         remaining_q <= load_pages;
         any_good    <= 1'b0;
         any_err     <= 1'b0;
         marked      <= 1'b0;
      end else if (step) begin
         remaining_q <= remaining_q - (PPB_LG2+1)'(1);
         if (step_ok) begin
            any_good <= 1'b1;
            if (step_marked) marked <= 1'b1;
         end else begin
            any_err <= 1'b1;
         end
      end
   end

   assign last = (remaining_q == (PPB_LG2+1)'(1));

   // R6: a page result never arrives once the block's page budget is spent
   p_step_in_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> remaining_q != '0);
   // R6: every block is given between one page and a full block
   p_load_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_pages != '0) && (load_pages <= PPB_CNT));
endmodule

// File: rtl/nand_boot_loader.sv
module nand_boot_loader
   import nbl_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SIZE_W   = 32,
   parameter int PAGE_W   = 19,
   parameter int PAGE_LG2 = 11,
   parameter int PPB_LG2  = 6,
   parameter int SUBPAGES = 4,
   parameter int CNT_W    = 2,
   parameter int FLIP_W   = CNT_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [ADDR_W-1:0]         start_offset,
   input  logic [SIZE_W-1:0]         image_size,
   input  logic [ADDR_W-1:0]         dest_base,
   output logic                      busy,
   output logic                      done,
   output logic                      error,
   output logic [FLIP_W-1:0]         max_flips,
   output logic                      rd_req,
   output logic [PAGE_W-1:0]         rd_page,
   output logic [ADDR_W-1:0]         rd_dest,
   input  logic                      rd_gnt,
   input  logic                      rd_rsp,
   input  logic [SUBPAGES-1:0]       rd_sub_fail,
   input  logic [SUBPAGES-1:0]       rd_sub_flag,
   input  logic [SUBPAGES*CNT_W-1:0] rd_sub_cnt,
   input  logic [7:0]                rd_spare0,
   input  logic [7:0]                rd_spare1
);
   localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_LG2;
   localparam logic [PAGE_W-1:0] BLK_STEP   = PAGE_W'(1) << PPB_LG2;

   if (ADDR_W < PAGE_LG2 + PAGE_W) begin : g_chk_addr
      $error("nand_boot_loader: ADDR_W too narrow for PAGE_W pages");
   end

   ld_state_e         state_q;
   logic [PAGE_W-1:0] pg_base_q, pg_cur_q;
   logic [ADDR_W-1:0] dst_blk_q, dst_cur_q;
   logic [SIZE_W-1:0] left_q;
   logic              done_q, err_q;
   logic [FLIP_W-1:0] flips_q;

   logic              page_fail, page_marked;
   logic [FLIP_W-1:0] page_flips;
   logic [PPB_LG2:0]  blk_pages;
   logic [SIZE_W-1:0] blk_bytes;
   logic              blk_last, blk_good, blk_err, blk_marked, blk_bad;
   logic              rsp_now;
   logic [ADDR_W-1:0] off_pages;
   logic              unused_offset;

   assign off_pages     = start_offset >> PAGE_LG2;
   assign unused_offset = ^start_offset;
   assign rsp_now       = (state_q == ST_WAIT) && rd_rsp;
   assign blk_bad       = blk_marked || !blk_good;

   nbl_page_judge #(
      .SUBPAGES (SUBPAGES),
      .CNT_W    (CNT_W),
      .FLIP_W   (FLIP_W)
   ) judge_i (
      .sub_fail    (rd_sub_fail),
      .sub_flag    (rd_sub_flag),
      .sub_cnt     (rd_sub_cnt),
      .spare0      (rd_spare0),
      .spare1      (rd_spare1),
      .page_fail   (page_fail),
      .page_marked (page_marked),
      .page_flips  (page_flips)
   );

   nbl_block_span #(
      .PAGE_LG2 (PAGE_LG2),
      .PPB_LG2  (PPB_LG2),
      .SIZE_W   (SIZE_W)
   ) span_i (
      .bytes_left (left_q),
      .blk_pages  (blk_pages),
      .blk_bytes  (blk_bytes)
   );

   nbl_block_tally #(
      .PPB_LG2 (PPB_LG2)
   ) tally_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (state_q == ST_BLOCK),
      .load_pages  (blk_pages),
      .step        (rsp_now),
      .step_ok     (!page_fail),
      .step_marked (page_marked),
      .last        (blk_last),
      .any_good    (blk_good),
      .any_err     (blk_err),
      .marked      (blk_marked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pg_base_q <= '0;
         pg_cur_q  <= '0;
         dst_blk_q <= '0;
         dst_cur_q <= '0;
         left_q    <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         flips_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  done_q    <= (image_size == '0);
                  err_q     <= 1'b0;
                  flips_q   <= '0;
                  pg_base_q <= off_pages[PAGE_W-1:0];
                  dst_blk_q <= dest_base;
                  left_q    <= image_size;
                  if (image_size != '0) state_q <= ST_BLOCK;
               end
            end
            ST_BLOCK: begin
               pg_cur_q  <= pg_base_q;
               dst_cur_q <= dst_blk_q;
               state_q   <= ST_REQ;
            end
            ST_REQ: begin
               if (rd_gnt) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rd_rsp) begin
                  pg_cur_q  <= pg_cur_q + PAGE_W'(1);
                  dst_cur_q <= dst_cur_q + PAGE_BYTES;
                  if (!page_fail && (page_flips > flips_q)) flips_q <= page_flips;
                  if (blk_last || (!page_fail && page_marked)) state_q <= ST_DECIDE;
                  else                                         state_q <= ST_REQ;
               end
            end
            ST_DECIDE: begin
               if (!blk_bad && blk_err) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (!blk_bad && (left_q == blk_bytes)) begin
                  done_q  <= 1'b1;
                  left_q  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  if (!blk_bad) begin
                     dst_blk_q <= dst_blk_q + ADDR_W'(blk_bytes);
                     left_q    <= left_q - blk_bytes;
                  end
                  pg_base_q <= pg_base_q + BLK_STEP;
                  state_q   <= ST_BLOCK;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign error     = err_q;
   assign max_flips = flips_q;
   assign rd_req    = (state_q == ST_REQ);
   assign rd_page   = pg_cur_q;
   assign rd_dest   = dst_cur_q;

   // R9: an unanswered request keeps its page and destination
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_gnt |=> rd_req && $stable(rd_page) && $stable(rd_dest));
   // R4: a load never ends both ways
   p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));
   // R8: an outcome is only shown while idle
   p_outcome_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> !busy);
   // R8: without a new start the outcome is held
   p_outcome_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) && !start |=> $stable(done) && $stable(error));
   // R7: within one load the worst count never drops
   p_flips_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> max_flips >= $past(max_flips));
endmodule

// File: tb/nand_boot_loader_tb_top.sv
module nand_boot_loader_tb_top;
   localparam int ADDR_W = 32, SIZE_W = 32, PAGE_W = 12, PAGE_LG2 = 11;
   localparam int PPB_LG2 = 3, SUBPAGES = 4, CNT_W = 2, FLIP_W = 3;
   localparam int PPB = 1 << PPB_LG2;
   localparam int PGB = 1 << PAGE_LG2;
   localparam int BLKB = PPB * PGB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [ADDR_W-1:0] start_offset = '0, dest_base = '0;
   logic [SIZE_W-1:0] image_size = '0;
   logic busy, done, error;
   logic [FLIP_W-1:0] max_flips;
   logic rd_req;
   logic [PAGE_W-1:0] rd_page;
   logic [ADDR_W-1:0] rd_dest;
   logic rd_gnt = 1'b0, rd_rsp = 1'b0;
   logic [SUBPAGES-1:0] rd_sub_fail = '0, rd_sub_flag = '0;
   logic [SUBPAGES*CNT_W-1:0] rd_sub_cnt = '0;
   logic [7:0] rd_spare0 = 8'hFF, rd_spare1 = 8'hFF;

   always #2 clk = ~clk;

   nand_boot_loader #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PAGE_W(PAGE_W), .PAGE_LG2(PAGE_LG2),
      .PPB_LG2(PPB_LG2), .SUBPAGES(SUBPAGES), .CNT_W(CNT_W), .FLIP_W(FLIP_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
      .image_size(image_size), .dest_base(dest_base), .busy(busy), .done(done),
      .error(error), .max_flips(max_flips), .rd_req(rd_req), .rd_page(rd_page),
      .rd_dest(rd_dest), .rd_gnt(rd_gnt), .rd_rsp(rd_rsp), .rd_sub_fail(rd_sub_fail),
      .rd_sub_flag(rd_sub_flag), .rd_sub_cnt(rd_sub_cnt), .rd_spare0(rd_spare0),
      .rd_spare1(rd_spare1)
   );

   // flash image model, indexed by page number modulo 512
   bit [3:0] t_fail [512];
   bit [3:0] t_flag [512];
   bit [7:0] t_cnt  [512];
   bit [7:0] t_sp0  [512];
   bit [7:0] t_sp1  [512];
   int blk_mode [8];
   int blk_arg  [8];

   int got_n, exp_n, hold_bad;
   int got_pg [512], got_dst [512], exp_pg [512], exp_dst [512];
   bit exp_done, exp_err;
   int exp_flips;
   int checks = 0, errors = 0;
   bit finished = 0;
   int r_idx, r_p0, r_d0;

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // page-read engine model
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rd_req) begin
            r_p0 = int'(rd_page);
            r_d0 = int'(rd_dest);
            repeat ($urandom_range(0, 2)) @(negedge clk);
            if (!rd_req || int'(rd_page) != r_p0 || int'(rd_dest) != r_d0) hold_bad++;
            if (got_n < 512) begin
               got_pg[got_n]  = int'(rd_page);
               got_dst[got_n] = int'(rd_dest);
            end
            got_n++;
            r_idx = int'(rd_page) % 512;
            rd_gnt = 1'b1;
            @(negedge clk);
            rd_gnt = 1'b0;
            if (rd_req) hold_bad++;
            repeat ($urandom_range(0, 3)) begin
               @(negedge clk);
               if (rd_req) hold_bad++;
            end
            rd_sub_fail = t_fail[r_idx];
            rd_sub_flag = t_flag[r_idx];
            rd_sub_cnt  = t_cnt[r_idx];
            rd_spare0   = t_sp0[r_idx];
            rd_spare1   = t_sp1[r_idx];
            rd_rsp = 1'b1;
            @(negedge clk);
            rd_rsp = 1'b0;
         end
      end
   end

   function automatic int page_flips(input int k);
      int best = 0;
      for (int s = 0; s < SUBPAGES; s++) begin
         int f = t_flag[k][s] ? int'(t_cnt[k][s*CNT_W +: CNT_W]) + 1 : 0;
         if (f > best) best = f;
      end
      return best;
   endfunction

   function automatic bit [7:0] nonblank();
      return 8'($urandom_range(0, 254));
   endfunction

   // builds the flash image: clean pages, then per-block fault modes from start_page
   task automatic fill_blocks(input int start_page);
      for (int k = 0; k < 512; k++) begin
         t_fail[k] = '0;
         t_flag[k] = 4'($urandom);
         t_cnt[k]  = 8'($urandom);
         t_sp0[k]  = 8'hFF;
         t_sp1[k]  = 8'hFF;
      end
      for (int b = 0; b < 8; b++) begin
         int p = start_page + b * PPB;
         int a = blk_arg[b];
         case (blk_mode[b])
            1: if ($urandom_range(0, 1) == 0) t_sp0[(p+a)%512] = nonblank();
               else                           t_sp1[(p+a)%512] = nonblank();
            2: for (int i = 0; i < PPB; i++) t_fail[(p+i)%512] = 4'($urandom_range(1, 15));
            3: t_fail[(p+a)%512] = 4'($urandom_range(1, 15));
            4: begin
                  t_fail[(p+a)%512] = 4'($urandom_range(1, 15));
                  t_sp0[(p+a+1)%512] = nonblank();
               end
            default: ;
         endcase
      end
   endtask

   // reference walk computed from the requirements
   task automatic compute_expected(input int off, input int size, input int base);
      int pg = off / PGB;
      int left = size;
      int dst = base;
      exp_n = 0; exp_done = 0; exp_err = 0; exp_flips = 0;
      if (size == 0) begin
         exp_done = 1;
         return;
      end
      for (int guard = 0; guard < 60; guard++) begin
         int bp = (left + PGB - 1) / PGB;
         int good = 0, err = 0;
         bit bad = 0;
         int cp = pg, dd = dst;
         if (bp > PPB) bp = PPB;
         for (int i = 0; i < bp && !bad; i++) begin
            int k = cp % 512;
            exp_pg[exp_n] = cp; exp_dst[exp_n] = dd; exp_n++;
            if (t_fail[k] == 0) begin
               good++;
               if (page_flips(k) > exp_flips) exp_flips = page_flips(k);
               if (t_sp0[k] != 8'hFF || t_sp1[k] != 8'hFF) bad = 1;
            end else err++;
            cp++; dd += PGB;
         end
         if (good == 0) bad = 1;
         if (err > 0 && !bad) begin
            exp_err = 1;
            return;
         end
         if (!bad) begin
            int take = (left > BLKB) ? BLKB : left;
            dst += take; left -= take;
            if (left == 0) begin
               exp_done = 1;
               return;
            end
         end
         pg += PPB;
      end
   endtask

   task automatic do_run(input string tag, input int off, input int size, input int base, input bit poke);
      int n;
      int cyc = 0;
      compute_expected(off, size, base);
      got_n = 0; hold_bad = 0;
      @(negedge clk);
      start_offset = off; image_size = size; dest_base = base; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (size != 0) chk(busy && !done && !error, "R8", "start clears outcome and sets busy", {busy, done, error}, 3'b100);
      if (poke) begin
         repeat (6) @(negedge clk);
         start_offset = 0; image_size = 1; dest_base = 32'hDEAD_0000; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!(done || error) && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc < 20000, "R5", {tag, " run finishes"}, cyc, 0);
      repeat (3) @(negedge clk);
      chk(got_n == exp_n, tag, "request count", got_n, exp_n);
      n = (got_n < exp_n) ? got_n : exp_n;
      if (n > 512) n = 512;
      for (int i = 0; i < n; i++) begin
         chk(got_pg[i] == exp_pg[i], tag, $sformatf("page of request %0d", i), got_pg[i], exp_pg[i]);
         chk(got_dst[i] == exp_dst[i], "R1", $sformatf("destination of request %0d", i), got_dst[i], exp_dst[i]);
      end
      chk(done == exp_done, "R5", {tag, " done"}, done, exp_done);
      chk(error == exp_err, "R4", {tag, " error"}, error, exp_err);
      chk(int'(max_flips) == exp_flips, "R7", {tag, " max_flips"}, max_flips, exp_flips);
      chk(hold_bad == 0, "R9", {tag, " request handshake"}, hold_bad, 0);
      chk(!busy, "R8", {tag, " idle at end"}, busy, 0);
   endtask

   task automatic clear_modes();
      for (int b = 0; b < 8; b++) begin
         blk_mode[b] = 0;
         blk_arg[b]  = 0;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      clear_modes();
      fill_blocks(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(!busy && !rd_req && !done && !error, "R10", "idle flags after reset",
          {busy, rd_req, done, error}, 0);
      chk(max_flips == '0, "R10", "max_flips after reset", max_flips, 0);

      // R8: zero length finishes at once with no request
      do_run("R8", 3 * PGB, 0, 32'h1000, 0);

      // R6: partial last block of one page, unaligned offset
      clear_modes();
      fill_blocks(5);
      do_run("R6", 5 * PGB + 100, 3 * BLKB + 1, 32'h8000_0000, 0);

      // R2: marker on the first page of the first block
      clear_modes(); blk_mode[0] = 1; blk_arg[0] = 0;
      fill_blocks(2);
      do_run("R2", 2 * PGB, BLKB, 32'h0001_0000, 0);

      // R2: marker part-way through, scan stops there
      clear_modes(); blk_mode[0] = 1; blk_arg[0] = 3;
      fill_blocks(0);
      do_run("R2", 0, 2 * BLKB - 5, 32'h0002_0000, 0);

      // R3: wholly unreadable block is skipped
      clear_modes(); blk_mode[0] = 2;
      fill_blocks(1);
      do_run("R3", PGB + 7, BLKB + PGB, 32'h0003_0000, 0);

      // R4: failure in an otherwise good block aborts
      clear_modes(); blk_mode[1] = 3; blk_arg[1] = 2;
      fill_blocks(0);
      do_run("R4", 0, 3 * BLKB, 32'h0004_0000, 0);

      // R4: failure forgiven because the same block is marked
      clear_modes(); blk_mode[0] = 4; blk_arg[0] = 1;
      fill_blocks(4);
      do_run("R4", 4 * PGB, BLKB, 32'h0005_0000, 0);

      // R8: start while busy is ignored; outcome then held
      clear_modes(); blk_mode[1] = 1; blk_arg[1] = 5;
      fill_blocks(3);
      do_run("R8", 3 * PGB, 2 * BLKB, 32'h0006_0000, 1);
      repeat (10) @(negedge clk);
      chk(done && !error, "R8", "done held while idle", done, 1);

      // R5: exact multiple of block size with skips in between
      clear_modes(); blk_mode[0] = 2; blk_mode[2] = 1; blk_arg[2] = 7;
      fill_blocks(0);
      do_run("R5", 0, 2 * BLKB, 32'h0007_0000, 0);

      // constrained random loads
      for (int r = 0; r < 20; r++) begin
         int off = $urandom_range(0, 40) * PGB + $urandom_range(0, PGB - 1);
         for (int b = 0; b < 8; b++) begin
            int sel = $urandom_range(0, 19);
            blk_mode[b] = (sel < 12) ? 0 : (sel < 14) ? 1 : (sel < 16) ? 2 : (sel < 18) ? 3 : 4;
            blk_arg[b]  = (blk_mode[b] == 4) ? $urandom_range(0, PPB - 2) : $urandom_range(0, PPB - 1);
         end
         fill_blocks(off / PGB);
         do_run("R1", off, $urandom_range(1, 4 * BLKB), int'($urandom), 0);
      end
      summary();
   end
endmodule